// File: doc/BRIEF.md
# Split-Ended Instruction Packet Aligner

This block slices variable-length instruction packets out of fixed-width instruction bundles. Inside a bundle, fixed-size packet descriptors (caps) are packed downward from the most significant end. Packet bodies are packed upward from the least significant end. A body holds one 20-bit head for each active issue slot, in slot order, and then the packet's tail bits. The block keeps one pointer into each end. Each time its output register is free, it decodes the cap at the top pointer and takes the matching body at the bottom pointer. It then presents the cap fields, the heads placed at fixed slot positions and the tail bits on a registered valid/ready output, and advances both pointers.

A cap carries everything the slicer needs: a slot-valid mask and a total tail length. No per-instruction dispatch bits are required. The block lets a bundle go, and asks for the next one, in two cases: it meets the end-of-bundle code, or the next packet would run the two pointers into each other. No packet is emitted in the cycle a bundle is dropped.

Top module: `pkt_align_top`

## Requirements
- R1: After reset `pktValid` is 0 and `bundleReady` is 1.
- R2: A cap is the 14 bits directly below the cap pointer, which starts at bit 511. The fields run from the cap's most significant bit downward: mode[13:12], slot mask[11:8] (bit 8 is slot 0), tail length[7:4], ping-pong[3:2], SIMD[1], conditional[0]. Each emitted packet advances the cap pointer by exactly 14 bits.
- R3: For modes 00 (VLIW) and 01 (differential), one 20-bit head is taken from the body for each set mask bit, lowest slot at the lowest address. Each head appears on `pktHeads[20*k +: 20]` for its slot k, and slots that are not set read as zero.
- R4: The tail length field counts 4-bit units. Exactly 4×length bits that follow the heads appear right-aligned on `pktTail`, and the bits above them are zero.
- R5: A mode 11 (scalar) cap consumes no heads, only its tail. It is output with mask 0 and all heads zero.
- R6: A mode 10 cap produces no packet. The bundle is released, and `bundleReady` returns to 1 on the following cycle.
- R7: When 14 + the body length would carry the cap pointer past the body pointer, the packet is not emitted and the bundle is released as in R6.
- R8: With SIMD set, only the heads of slots 0–1 are read from the bundle. At the output, mask bits 3:2 and heads of slots 2–3 repeat those of slots 0–1.
- R9: While `pktValid` is 1 and `pktReady` is 0, all packet outputs and both pointers hold. The packet that follows a stall is the next one in the bundle.
- R10: A mode 01 (differential) packet is sliced and presented exactly as a mode 00 packet, with its mode passed through.
- R11: Ping-pong, SIMD and conditional bits are passed to the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bundleIn | input | 512 | Instruction bundle |
| bundleValid | input | 1 | Bundle offered |
| bundleReady | output | 1 | Block wants a new bundle (fetch request) |
| pktReady | input | 1 | Consumer accepts the presented packet |
| pktValid | output | 1 | Packet presented |
| pktMode | output | 2 | Cap mode (00 VLIW, 01 differential, 11 scalar) |
| pktMask | output | 4 | Slot-valid mask after SIMD expansion |
| pktPp | output | 2 | Ping-pong bits, one per cluster |
| pktSimd | output | 1 | SIMD bit |
| pktCond | output | 1 | Conditional-execution bit |
| pktHeads | output | 80 | Four 20-bit heads, slot k at bits 20k+19:20k |
| pktTailLen | output | 4 | Tail length in 4-bit units |
| pktTail | output | 60 | Tail bits, right-aligned, zero above the length |

## Verification
The bench builds the block with its default geometry: 512-bit bundles, 14-bit caps, four 20-bit slots and a 4-bit tail length. With these values, a packet with every slot active and a full 60-bit tail takes 154 bits. Three such packets leave the pointers close enough that a fourth must trigger the collision drop. The same sizes allow single-packet bundles, a bundle that holds only an end code, and long runs of short packets. Those runs pass over many pointer offsets while the consumer stalls at irregular moments.

// File: rtl/pkt_align_pkg.sv
package pkt_align_pkg;
  localparam int BUNDLE_W  = 512;
  localparam int CAP_W     = 14;
  localparam int HEAD_W    = 20;
  localparam int SLOTS     = 4;
  localparam int HALF      = SLOTS / 2;
  localparam int TLEN_W    = 4;
  localparam int TAIL_UNIT = 4;
  localparam int TAIL_MAX  = ((1 << TLEN_W) - 1) * TAIL_UNIT;
  localparam int PTR_W     = $clog2(BUNDLE_W + 1);
  localparam int SUM_W     = PTR_W + 2;

  typedef enum logic [1:0] {
    MODE_VLIW   = 2'b00,
    MODE_DIFF   = 2'b01,
    MODE_END    = 2'b10,
    MODE_SCALAR = 2'b11
  } mode_e;

  typedef struct packed {
    mode_e             mode;
    logic [SLOTS-1:0]  mask;
    logic [TLEN_W-1:0] tlen;
    logic [1:0]        pp;
    logic              simd;
    logic              cond;
  } cap_t;

  typedef struct packed {
    logic loadBundle;
    logic emit;
    logic dropBundle;
  } strobe_t;
endpackage

// File: rtl/pkt_align_ctrl.sv
module pkt_align_ctrl
  import pkt_align_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bundleValid,
  output logic             bundleReady,
  input  logic             pktValid,
  input  logic             pktReady,
  input  mode_e            capMode,
  input  logic             fits,
  input  logic [SUM_W-1:0] bodyLen,
  output logic [PTR_W-1:0] capPtr,
  output logic [PTR_W-1:0] htPtr,
  output strobe_t          strobe
);
  logic have;

  always_comb begin
    strobe = '0;
    if (!have) begin
      strobe.loadBundle = bundleValid;
    end else if (!pktValid || pktReady) begin
      if (capMode == MODE_END || !fits) strobe.dropBundle = 1'b1;
      else strobe.emit = 1'b1;
    end
  end

  assign bundleReady = !have;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      have   <= 1'b0;
      capPtr <= '0;
      htPtr  <= '0;
    end else if (strobe.loadBundle) begin
      have   <= 1'b1;
      capPtr <= '0;
      htPtr  <= '0;
    end else if (strobe.dropBundle) begin
      have <= 1'b0;
    end else if (strobe.emit) begin
      capPtr <= capPtr + PTR_W'(CAP_W);
      htPtr  <= htPtr + PTR_W'(bodyLen);
    end
  end

  // R7: the two pointers never pass each other
  p_ptr_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    have |-> (SUM_W'(capPtr) + SUM_W'(htPtr)) <= SUM_W'(BUNDLE_W));
  // R6: an accepted bundle restarts both pointers
  p_load_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bundleValid && bundleReady) |=> (capPtr == '0 && htPtr == '0 && !bundleReady));
  // R6: end code releases the bundle
  p_end_refetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (have && capMode == MODE_END && (!pktValid || pktReady)) |=> bundleReady);
  // R9: stall freezes pointers
  p_stall_ptr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> ($stable(capPtr) && $stable(htPtr)));
endmodule

// File: rtl/pkt_align_dp.sv
module pkt_align_dp
  import pkt_align_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [BUNDLE_W-1:0]       bundleIn,
  input  strobe_t                   strobe,
  input  logic [PTR_W-1:0]          capPtr,
  input  logic [PTR_W-1:0]          htPtr,
  input  logic                      pktReady,
  output mode_e                     capMode,
  output logic                      fits,
  output logic [SUM_W-1:0]          bodyLen,
  output logic                      pktValid,
  output mode_e                     pktMode,
  output logic [SLOTS-1:0]          pktMask,
  output logic [1:0]                pktPp,
  output logic                      pktSimd,
  output logic                      pktCond,
  output logic [SLOTS*HEAD_W-1:0]   pktHeads,
  output logic [TLEN_W-1:0]         pktTailLen,
  output logic [TAIL_MAX-1:0]       pktTail
);
  logic [BUNDLE_W-1:0]     bundleReg, capWin, htWin, shifted;
  cap_t                    capNow;
  logic [SLOTS-1:0]        usedMask, outMask;
  logic [HEAD_W-1:0]       rawHead [SLOTS];
  logic [SLOTS*HEAD_W-1:0] outHeads;
  logic [SUM_W-1:0]        off, tailBits;
  logic [TAIL_MAX-1:0]     tailVal;

  always_ff @(posedge clk) begin
    if (strobe.loadBundle) bundleReg <= bundleIn;
  end

  always_comb begin
    capWin  = bundleReg << capPtr;
    capNow  = cap_t'(capWin[BUNDLE_W-1 -: CAP_W]);
    capMode = capNow.mode;
    htWin   = bundleReg >> htPtr;
    if (capNow.mode == MODE_SCALAR) begin
      usedMask = '0;
      outMask  = '0;
    end else if (capNow.simd) begin
      usedMask = {{(SLOTS-HALF){1'b0}}, capNow.mask[HALF-1:0]};
      outMask  = {capNow.mask[HALF-1:0], capNow.mask[HALF-1:0]};
    end else begin
      usedMask = capNow.mask;
      outMask  = capNow.mask;
    end
    off = '0;
    for (int k = 0; k < SLOTS; k++) begin
      shifted    = htWin >> off;
      rawHead[k] = usedMask[k] ? shifted[HEAD_W-1:0] : '0;
      if (usedMask[k]) off = off + SUM_W'(HEAD_W);
    end
    tailBits = SUM_W'(capNow.tlen) * SUM_W'(TAIL_UNIT);
    shifted  = htWin >> off;
    tailVal  = shifted[TAIL_MAX-1:0] & ~({TAIL_MAX{1'b1}} << tailBits);
    bodyLen  = off + tailBits;
    fits     = (SUM_W'(capPtr) + SUM_W'(CAP_W) + SUM_W'(htPtr) + bodyLen) <= SUM_W'(BUNDLE_W);
    for (int k = 0; k < SLOTS; k++) begin
      outHeads[k*HEAD_W +: HEAD_W] = (capNow.simd && k >= HALF) ? rawHead[k-HALF] : rawHead[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pktValid   <= 1'b0;
      pktMode    <= MODE_VLIW;
      pktMask    <= '0;
      pktPp      <= '0;
      pktSimd    <= 1'b0;
      pktCond    <= 1'b0;
      pktHeads   <= '0;
      pktTailLen <= '0;
      pktTail    <= '0;
    end else if (strobe.emit) begin
      pktValid   <= 1'b1;
      pktMode    <= capNow.mode;
      pktMask    <= outMask;
      pktPp      <= capNow.pp;
      pktSimd    <= capNow.simd;
      pktCond    <= capNow.cond;
      pktHeads   <= outHeads;
      pktTailLen <= capNow.tlen;
      pktTail    <= tailVal;
    end else if (pktReady) begin
      pktValid <= 1'b0;
    end
  end

  // R8: SIMD output repeats cluster 0 in cluster 1
  p_simd_copy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktSimd) |->
      (pktHeads[SLOTS*HEAD_W-1 -: HALF*HEAD_W] == pktHeads[HALF*HEAD_W-1:0]
       && pktMask[SLOTS-1 -: HALF] == pktMask[HALF-1:0]));
  // R5: scalar packets carry no heads
  p_scalar_nohead_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktMode == MODE_SCALAR) |-> (pktMask == '0 && pktHeads == '0));
  // R4: nothing above the tail length
  p_tail_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> ((pktTail >> (SUM_W'(pktTailLen) * SUM_W'(TAIL_UNIT))) == '0));
  // R6: end code is never presented
  p_no_end_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> pktMode != MODE_END);
  // R9: stalled packet holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=>
      (pktValid && $stable(pktHeads) && $stable(pktTail) && $stable(pktMode) && $stable(pktMask)));
endmodule

// File: rtl/pkt_align_top.sv
module pkt_align_top
  import pkt_align_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BUNDLE_W-1:0]     bundleIn,
  input  logic                    bundleValid,
  output logic                    bundleReady,
  input  logic                    pktReady,
  output logic                    pktValid,
  output logic [1:0]              pktMode,
  output logic [SLOTS-1:0]        pktMask,
  output logic [1:0]              pktPp,
  output logic                    pktSimd,
  output logic                    pktCond,
  output logic [SLOTS*HEAD_W-1:0] pktHeads,
  output logic [TLEN_W-1:0]       pktTailLen,
  output logic [TAIL_MAX-1:0]     pktTail
);
  strobe_t          strobe;
  mode_e            capMode, modeOut;
  logic             fits;
  logic [SUM_W-1:0] bodyLen;
  logic [PTR_W-1:0] capPtr, htPtr;

  pkt_align_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bundleValid(bundleValid), .bundleReady(bundleReady),
    .pktValid(pktValid), .pktReady(pktReady), .capMode(capMode), .fits(fits),
    .bodyLen(bodyLen), .capPtr(capPtr), .htPtr(htPtr), .strobe(strobe)
  );

  pkt_align_dp u_dp (
    .clk(clk), .rstN(rstN), .bundleIn(bundleIn), .strobe(strobe), .capPtr(capPtr),
    .htPtr(htPtr), .pktReady(pktReady), .capMode(capMode), .fits(fits), .bodyLen(bodyLen),
    .pktValid(pktValid), .pktMode(modeOut), .pktMask(pktMask), .pktPp(pktPp),
    .pktSimd(pktSimd), .pktCond(pktCond), .pktHeads(pktHeads), .pktTailLen(pktTailLen),
    .pktTail(pktTail)
  );

  assign pktMode = modeOut;
endmodule

// File: tb/sim_pkt_align_top.sv
module sim_pkt_align_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [511:0] bundleIn = '0;
  logic         bundleValid = 1'b0;
  logic         bundleReady;
  logic         pktReady = 1'b0;
  logic         pktValid;
  logic [1:0]   pktMode;
  logic [3:0]   pktMask;
  logic [1:0]   pktPp;
  logic         pktSimd, pktCond;
  logic [79:0]  pktHeads;
  logic [3:0]   pktTailLen;
  logic [59:0]  pktTail;

  pkt_align_top u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [1:0] mode; logic [3:0] mask; logic [3:0] tlen; logic [1:0] pp;
    logic s; logic c; logic [79:0] heads; logic [59:0] tail;
  } desc_t;
  typedef struct {
    logic [1:0] mode; logic [3:0] mask; logic [1:0] pp; logic s; logic c;
    logic [79:0] heads; logic [3:0] tlen; logic [59:0] tail; string tag;
  } exp_t;

  exp_t         expQ[$];
  int           checks = 0, fails = 0, seq = 0, cyc = 0;
  int           cp = 0, bp = 0, stallMode = 0;
  logic [511:0] bb;
  logic         prevStall = 1'b0;
  logic [153:0] prevOut;

  function automatic logic [153:0] outVec();
    return {pktMode, pktMask, pktPp, pktSimd, pktCond, pktHeads, pktTailLen, pktTail};
  endfunction

  task automatic mk(input logic [1:0] mode, input logic [3:0] mask, input logic [3:0] tlen,
                    input logic [1:0] pp, input logic s, input logic c, output desc_t d);
    d.mode = mode; d.mask = mask; d.tlen = tlen; d.pp = pp; d.s = s; d.c = c;
    for (int k = 0; k < 4; k++) d.heads[k*20 +: 20] = 20'(seq * 977 + k * 131 + 20'h5A5A1);
    d.tail = {28'(seq * 7919 + 3), 32'(seq * 2654435 + 32'h9E3779B1)};
    seq++;
  endtask

  task automatic newBundle();
    bb = '0; cp = 0; bp = 0;
  endtask

  task automatic addPkt(input desc_t d, input string tag);
    logic [3:0] used, om; int len; exp_t e;
    used = (d.mode == 2'b11) ? 4'b0 : (d.s ? {2'b00, d.mask[1:0]} : d.mask);
    om   = (d.mode == 2'b11) ? 4'b0 : (d.s ? {d.mask[1:0], d.mask[1:0]} : d.mask);
    len  = $countones(used) * 20 + d.tlen * 4;
    if (cp + 14 + bp + len + 14 > 512) begin
      $display("bench setup: packet skipped");
      return;
    end
    bb[511-cp -: 14] = {d.mode, d.mask, d.tlen, d.pp, d.s, d.c};
    cp += 14;
    for (int k = 0; k < 4; k++) if (used[k]) begin
      for (int i = 0; i < 20; i++) bb[bp+i] = d.heads[k*20+i];
      bp += 20;
    end
    for (int i = 0; i < d.tlen * 4; i++) bb[bp+i] = d.tail[i];
    bp += d.tlen * 4;
    e.mode = d.mode; e.mask = om; e.pp = d.pp; e.s = d.s; e.c = d.c; e.tlen = d.tlen; e.tag = tag;
    e.heads = '0;
    for (int k = 0; k < 4; k++) begin
      int src = (d.s && k >= 2) ? k - 2 : k;
      if (om[k]) e.heads[k*20 +: 20] = d.heads[src*20 +: 20];
    end
    e.tail = d.tail & ~({60{1'b1}} << (d.tlen * 4));
    expQ.push_back(e);
  endtask

  task automatic addEnd();
    bb[511-cp -: 14] = {2'b10, 12'h5A3};
  endtask

  task automatic sendBundle();
    @(negedge clk);
    while (!bundleReady) @(negedge clk);
    bundleIn = bb; bundleValid = 1'b1;
    @(negedge clk);
    bundleValid = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    logic rdy; exp_t e; logic [153:0] ev;
    cyc++;
    if (rstN) begin
      if (prevStall) check(outVec() == prevOut && pktValid, "R9 stall hold", 160'(outVec()), 160'(prevOut));
      case (stallMode)
        0: rdy = 1'b1;
        1: rdy = (cyc % 3) == 0;
        default: rdy = (cyc % 7) > 3;
      endcase
      pktReady = rdy;
      prevStall = pktValid && !rdy;
      prevOut = outVec();
      if (pktValid && rdy) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6/R7 unexpected packet", 160'(outVec()), 160'(0));
        end else begin
          e = expQ.pop_front();
          ev = {e.mode, e.mask, e.pp, e.s, e.c, e.heads, e.tlen, e.tail};
          check(outVec() == ev, e.tag, 160'(outVec()), 160'(ev));
        end
      end
    end
  end

  initial begin
    while (cyc < 50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected<50000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
    $finish;
  end

  initial begin
    desc_t d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!pktValid && bundleReady, "R1 reset state", 160'({pktValid, bundleReady}), 160'(2'b01));

    // R2 R3 R4 R11: VLIW packets with assorted masks and tail lengths
    newBundle();
    mk(2'b00, 4'b1111, 4'd0, 2'b01, 1'b0, 1'b1, d); addPkt(d, "R3 all slots");
    mk(2'b00, 4'b0101, 4'd2, 2'b10, 1'b0, 1'b0, d); addPkt(d, "R4 8-bit tail");
    mk(2'b00, 4'b1000, 4'd15, 2'b11, 1'b0, 1'b1, d); addPkt(d, "R4 full tail");
    mk(2'b00, 4'b0000, 4'd3, 2'b00, 1'b0, 1'b0, d); addPkt(d, "R2 no heads");
    mk(2'b00, 4'b0110, 4'd1, 2'b01, 1'b0, 1'b1, d); addPkt(d, "R11 flags");
    addEnd(); sendBundle();

    // R5 R10 R9: scalar and differential with a stalling consumer
    stallMode = 1;
    newBundle();
    mk(2'b11, 4'b1111, 4'd1, 2'b10, 1'b0, 1'b0, d); addPkt(d, "R5 scalar short");
    mk(2'b01, 4'b1011, 4'd5, 2'b01, 1'b0, 1'b1, d); addPkt(d, "R10 differential");
    mk(2'b11, 4'b0000, 4'd7, 2'b11, 1'b1, 1'b1, d); addPkt(d, "R5 scalar simd bit");
    mk(2'b00, 4'b1001, 4'd4, 2'b00, 1'b0, 1'b0, d); addPkt(d, "R9 after stall");
    addEnd(); sendBundle();

    // R8: SIMD replication
    stallMode = 2;
    newBundle();
    mk(2'b00, 4'b1011, 4'd3, 2'b11, 1'b1, 1'b0, d); addPkt(d, "R8 simd both");
    mk(2'b00, 4'b0110, 4'd0, 2'b01, 1'b1, 1'b1, d); addPkt(d, "R8 simd slot1");
    mk(2'b01, 4'b0001, 4'd6, 2'b10, 1'b1, 1'b0, d); addPkt(d, "R8 simd diff");
    addEnd(); sendBundle();

    // R6: bundle holding only an end code
    stallMode = 0;
    newBundle(); addEnd(); sendBundle();

    // R7: pointers would collide
    newBundle();
    for (int n = 0; n < 3; n++) begin
      mk(2'b00, 4'b1111, 4'd15, 2'(n), 1'b0, 1'b0, d); addPkt(d, "R7 before collision");
    end
    bb[511-cp -: 14] = {2'b00, 4'b1111, 4'd15, 4'b0};
    sendBundle();

    // recovery after drop
    newBundle();
    mk(2'b00, 4'b0011, 4'd9, 2'b01, 1'b0, 1'b1, d); addPkt(d, "R6 next bundle");
    addEnd(); sendBundle();

    while (expQ.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check(bundleReady && !pktValid, "R6 idle after end", 160'({bundleReady, pktValid}), 160'(2'b10));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule